// File: doc/BRIEF.md
# Root Port Command Register and Traffic Gate

This block holds the 16-bit command register of a bridge-style root port and applies its enable bits to the traffic and events that pass through the port. Software reaches the register through a small 16-bit configuration interface with a byte address and two byte-lane enables. Only the command word at byte offset 04h is decoded. Reads of any other address return zero, and writes to any other address are dropped.

Three decisions are made from the register. The first is whether cycles that start at the downstream device go upstream or are master-aborted. The second is whether upstream memory and I/O cycles that hit the port's windows go downstream or are master-aborted. The window hit flags arrive as inputs. The third is whether the port raises its own legacy interrupt and its system-error message. The interrupt-disable bit masks only the port's own hot-plug and power-management interrupt. Legacy interrupt messages that arrive from downstream devices always pass through. An enabled MSI also suppresses the port's own legacy interrupt. The own interrupt is kept as a level. Masking it while it is asserted produces a deassert message, so that no interrupt is left stuck.

Top module: `rpc_cmd_gate`

## Requirements
- R1: After reset the command word reads 0000h at byte offset 04h, and every gating output is in its disabled state.
- R2: Only bits 10, 8, 6, 2, 1 and 0 can be written (mask 0547h). All other bits read as zero. cfgByteEn[0] enables writes to bits 7:0 and cfgByteEn[1] enables writes to bits 15:8.
- R3: A downstream-originated cycle (dnReq=1) gives dnFwd=1 when bit 2 is 1 and dnAbort=1 when bit 2 is 0, in the same cycle. With dnReq=0 both outputs are 0.
- R4: An upstream memory cycle that hits the window (upMemReq=1, upMemHit=1) gives upMemFwd=1 when bit 1 is 1 and upMemAbort=1 when bit 1 is 0. A miss gives neither.
- R5: An upstream I/O cycle that hits the window (upIoReq=1, upIoHit=1) gives upIoFwd=1 when bit 0 is 1 and upIoAbort=1 when bit 0 is 0. A miss gives neither.
- R6: While bit 10 is 0 and msiEn is 0, a pending port event (portEvent=1) raises intxOwn one cycle later, together with a single-cycle intxAssertMsg pulse. Clearing the event lowers intxOwn one cycle later, together with a single-cycle intxDeassertMsg pulse.
- R7: With bit 10 set or msiEn high, no assert message is produced. If either one becomes active while intxOwn is high, intxOwn falls one cycle later and a single intxDeassertMsg pulse is emitted.
- R8: Downstream assert and deassert messages (dnIntxAssert, dnIntxDeassert) appear on fwdIntxAssert and fwdIntxDeassert in the same cycle, whatever the values of bit 10 and msiEn.
- R9: serrMsg is a one-cycle pulse, issued one cycle after the AND of sysErrStatus and bit 8 rises. It is not repeated while that AND stays high. With bit 8 at 0, no pulse is issued.
- R10: parErrRespEn follows bit 6 of the command word.
- R11: Reads of any byte address other than 04h return 0000h. Writes to any other address leave the command word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | CFG_ADDR_W | Configuration byte address |
| cfgWr | input | 1 | Configuration write strobe |
| cfgByteEn | input | 2 | Byte-lane write enables |
| cfgWrData | input | 16 | Configuration write data |
| cfgRdData | output | 16 | Configuration read data (combinational) |
| dnReq | input | 1 | Cycle from the downstream device is presented |
| dnFwd | output | 1 | Forward the downstream cycle upstream |
| dnAbort | output | 1 | Master-abort the downstream cycle |
| upMemReq | input | 1 | Upstream memory cycle is presented |
| upMemHit | input | 1 | Memory cycle falls within the window |
| upMemFwd | output | 1 | Forward the memory cycle downstream |
| upMemAbort | output | 1 | Master-abort the memory cycle |
| upIoReq | input | 1 | Upstream I/O cycle is presented |
| upIoHit | input | 1 | I/O cycle falls within the window |
| upIoFwd | output | 1 | Forward the I/O cycle downstream |
| upIoAbort | output | 1 | Master-abort the I/O cycle |
| portEvent | input | 1 | Pending hot-plug or power-management interrupt |
| msiEn | input | 1 | MSI is enabled for the port |
| intxOwn | output | 1 | Level of the port's own legacy interrupt |
| intxAssertMsg | output | 1 | Pulse: internal assert message |
| intxDeassertMsg | output | 1 | Pulse: internal deassert message |
| dnIntxAssert | input | 1 | Assert message received from downstream |
| dnIntxDeassert | input | 1 | Deassert message received from downstream |
| fwdIntxAssert | output | 1 | Forwarded downstream assert message |
| fwdIntxDeassert | output | 1 | Forwarded downstream deassert message |
| sysErrStatus | input | 1 | Signaled-system-error status |
| serrMsg | output | 1 | Pulse: system-error message |
| parErrRespEn | output | 1 | Parity error response enable |

## Verification
The bench writes all ones, both through a single byte lane and through both lanes, to show that reserved bits never stick. A design with a wrong write mask would read back something other than 0547h or 0047h. It masks the port's interrupt while that interrupt is asserted, once through bit 10 and once through msiEn. A design that only blocks new assertions would leave intxOwn stuck high and would never emit the deassert message. It holds sysErrStatus high for several cycles and expects exactly one serrMsg pulse, so a level-driven design would be caught. It also sets bit 10 and msiEn and checks that downstream interrupt messages still pass through, which catches a design that masks forwarded interrupts as well.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int CMD_W = 16;
  localparam int LANES = CMD_W / 8;
  localparam logic [CMD_W-1:0] CMD_WR_MASK = 16'h0547;

  localparam int BIT_IO_EN   = 0;
  localparam int BIT_MEM_EN  = 1;
  localparam int BIT_BM_EN   = 2;
  localparam int BIT_PAR_EN  = 6;
  localparam int BIT_SERR_EN = 8;
  localparam int BIT_INT_DIS = 10;

  typedef struct packed {
    logic             rdSel;
    logic [LANES-1:0] wrLane;
  } cmdStrobe_t;
endpackage

// File: rtl/rpc_cmd_ctrl.sv
module rpc_cmd_ctrl
  import rpc_pkg::*;
#(
  parameter int CFG_ADDR_W = 8,
  parameter logic [CFG_ADDR_W-1:0] CMD_OFFSET = 'h04
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic                  cfgWr,
  input  logic [LANES-1:0]      cfgByteEn,
  input  logic                  intDis,
  input  logic                  serrEn,
  input  logic                  portEvent,
  input  logic                  msiEn,
  input  logic                  sysErrStatus,
  output cmdStrobe_t            strobe,
  output logic                  intxOwn,
  output logic                  intxAssertMsg,
  output logic                  intxDeassertMsg,
  output logic                  serrMsg
);
  logic addrHit;
  logic intxWant;
  logic serrArm;
  logic serrArmQ;

  assign addrHit = (cfgAddr == CMD_OFFSET);

  always_comb begin
    strobe.rdSel = addrHit;
    for (int i = 0; i < LANES; i++) begin
      strobe.wrLane[i] = cfgWr & addrHit & cfgByteEn[i];
    end
  end

  // Own interrupt is a level; edges of that level become messages.
  assign intxWant = portEvent & ~intDis & ~msiEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intxOwn         <= 1'b0;
      intxAssertMsg   <= 1'b0;
      intxDeassertMsg <= 1'b0;
    end else begin
      intxOwn         <= intxWant;
      intxAssertMsg   <= intxWant & ~intxOwn;
      intxDeassertMsg <= ~intxWant & intxOwn;
    end
  end

  // System-error message on the rising edge of (status AND enable).
  assign serrArm = sysErrStatus & serrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serrArmQ <= 1'b0;
      serrMsg  <= 1'b0;
    end else begin
      serrArmQ <= serrArm;
      serrMsg  <= serrArm & ~serrArmQ;
    end
  end
endmodule

// File: rtl/rpc_cmd_dp.sv
module rpc_cmd_dp
  import rpc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cmdStrobe_t       strobe,
  input  logic [CMD_W-1:0] cfgWrData,
  output logic [CMD_W-1:0] cfgRdData,
  output logic [CMD_W-1:0] cmdWord,
  input  logic             dnReq,
  output logic             dnFwd,
  output logic             dnAbort,
  input  logic             upMemReq,
  input  logic             upMemHit,
  output logic             upMemFwd,
  output logic             upMemAbort,
  input  logic             upIoReq,
  input  logic             upIoHit,
  output logic             upIoFwd,
  output logic             upIoAbort
);
  logic [CMD_W-1:0] cmdQ;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmdQ[ln*8 +: 8] <= '0;
      end else if (strobe.wrLane[ln]) begin
        cmdQ[ln*8 +: 8] <= cfgWrData[ln*8 +: 8] & CMD_WR_MASK[ln*8 +: 8];
      end
    end
  end

  assign cmdWord   = cmdQ;
  assign cfgRdData = strobe.rdSel ? cmdQ : '0;

  logic memHit;
  logic ioHit;
  assign memHit = upMemReq & upMemHit;
  assign ioHit  = upIoReq & upIoHit;

  assign dnFwd      = dnReq  &  cmdQ[BIT_BM_EN];
  assign dnAbort    = dnReq  & ~cmdQ[BIT_BM_EN];
  assign upMemFwd   = memHit &  cmdQ[BIT_MEM_EN];
  assign upMemAbort = memHit & ~cmdQ[BIT_MEM_EN];
  assign upIoFwd    = ioHit  &  cmdQ[BIT_IO_EN];
  assign upIoAbort  = ioHit  & ~cmdQ[BIT_IO_EN];
endmodule

// File: rtl/rpc_cmd_gate.sv
module rpc_cmd_gate
  import rpc_pkg::*;
#(
  parameter int CFG_ADDR_W = 8,
  parameter logic [CFG_ADDR_W-1:0] CMD_OFFSET = 'h04
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic                  cfgWr,
  input  logic [1:0]            cfgByteEn,
  input  logic [15:0]           cfgWrData,
  output logic [15:0]           cfgRdData,
  input  logic                  dnReq,
  output logic                  dnFwd,
  output logic                  dnAbort,
  input  logic                  upMemReq,
  input  logic                  upMemHit,
  output logic                  upMemFwd,
  output logic                  upMemAbort,
  input  logic                  upIoReq,
  input  logic                  upIoHit,
  output logic                  upIoFwd,
  output logic                  upIoAbort,
  input  logic                  portEvent,
  input  logic                  msiEn,
  output logic                  intxOwn,
  output logic                  intxAssertMsg,
  output logic                  intxDeassertMsg,
  input  logic                  dnIntxAssert,
  input  logic                  dnIntxDeassert,
  output logic                  fwdIntxAssert,
  output logic                  fwdIntxDeassert,
  input  logic                  sysErrStatus,
  output logic                  serrMsg,
  output logic                  parErrRespEn
);
  cmdStrobe_t       strobe;
  logic [CMD_W-1:0] cmdWord;

  rpc_cmd_ctrl #(.CFG_ADDR_W(CFG_ADDR_W), .CMD_OFFSET(CMD_OFFSET)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWr(cfgWr), .cfgByteEn(cfgByteEn),
    .intDis(cmdWord[BIT_INT_DIS]), .serrEn(cmdWord[BIT_SERR_EN]),
    .portEvent(portEvent), .msiEn(msiEn), .sysErrStatus(sysErrStatus),
    .strobe(strobe), .intxOwn(intxOwn), .intxAssertMsg(intxAssertMsg),
    .intxDeassertMsg(intxDeassertMsg), .serrMsg(serrMsg)
  );

  rpc_cmd_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .cmdWord(cmdWord),
    .dnReq(dnReq), .dnFwd(dnFwd), .dnAbort(dnAbort),
    .upMemReq(upMemReq), .upMemHit(upMemHit), .upMemFwd(upMemFwd), .upMemAbort(upMemAbort),
    .upIoReq(upIoReq), .upIoHit(upIoHit), .upIoFwd(upIoFwd), .upIoAbort(upIoAbort)
  );

  // Downstream interrupt messages bypass the interrupt-disable and MSI gating.
  assign fwdIntxAssert   = dnIntxAssert;
  assign fwdIntxDeassert = dnIntxDeassert;
  assign parErrRespEn    = cmdWord[BIT_PAR_EN];
endmodule

// File: rtl/rpc_cmd_gate_chk.sv
module rpc_cmd_gate_chk
  import rpc_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cfgRdData,
  input logic        dnReq,
  input logic        dnFwd,
  input logic        dnAbort,
  input logic        upMemReq,
  input logic        upMemHit,
  input logic        upMemFwd,
  input logic        upMemAbort,
  input logic        upIoFwd,
  input logic        upIoAbort,
  input logic        msiEn,
  input logic        intxOwn,
  input logic        intxAssertMsg,
  input logic        intxDeassertMsg,
  input logic        serrMsg
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData & ~CMD_WR_MASK) == '0);
  a_r3_dn_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dnFwd, dnAbort}) && ((dnFwd || dnAbort) == dnReq));
  a_r4_mem_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    (upMemFwd || upMemAbort) |-> (upMemReq && upMemHit));
  a_r5_io_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({upIoFwd, upIoAbort}));
  a_r6_assert_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    intxAssertMsg |-> (intxOwn && !$past(intxOwn)));
  a_r7_deassert_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    intxDeassertMsg |-> (!intxOwn && $past(intxOwn)));
  a_r7_msi_blocks_assert: assert property (@(posedge clk) disable iff (!rstN)
    msiEn |=> !intxAssertMsg);
  a_r9_serr_single: assert property (@(posedge clk) disable iff (!rstN)
    serrMsg |=> !serrMsg);
endmodule

bind rpc_cmd_gate rpc_cmd_gate_chk chk_i (.*);

// File: tb/rpc_cmd_gate_tb_top.sv
module rpc_cmd_gate_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cfgAddr = 8'h04;
  logic cfgWr = 1'b0;
  logic [1:0] cfgByteEn = 2'b00;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData;
  logic dnReq = 0, upMemReq = 0, upMemHit = 0, upIoReq = 0, upIoHit = 0;
  logic dnFwd, dnAbort, upMemFwd, upMemAbort, upIoFwd, upIoAbort;
  logic portEvent = 0, msiEn = 0, dnIntxAssert = 0, dnIntxDeassert = 0, sysErrStatus = 0;
  logic intxOwn, intxAssertMsg, intxDeassertMsg, fwdIntxAssert, fwdIntxDeassert;
  logic serrMsg, parErrRespEn;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  rpc_cmd_gate dut_i (.*);

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    cfgAddr = a; cfgByteEn = be; cfgWrData = d; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0; cfgAddr = 8'h04; cfgByteEn = 2'b00;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdData;
    cfgAddr = 8'h04;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    cfgRead(8'h04, d);
    check(d, 16'h0000, "R1 reset word");
    dnReq = 1; #1;
    check({dnFwd, dnAbort}, 2'b01, "R1 reset bus master off");
    dnReq = 0;
    check({intxOwn, serrMsg, parErrRespEn}, 3'b000, "R1 reset outputs");
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    cfgWrite(8'h04, 2'b11, 16'hFFFF);
    cfgRead(8'h04, d);
    check(d, 16'h0547, "R2 all ones masked");
    cfgWrite(8'h04, 2'b11, 16'h0000);
    cfgWrite(8'h04, 2'b01, 16'hFFFF);
    cfgRead(8'h04, d);
    check(d, 16'h0047, "R2 low lane only");
    cfgWrite(8'h04, 2'b11, 16'h0000);
  endtask

  task automatic t_other_addr();
    logic [15:0] d;
    cfgWrite(8'h04, 2'b11, 16'h0004);
    cfgWrite(8'h06, 2'b11, 16'hFFFF);
    cfgRead(8'h04, d);
    check(d, 16'h0004, "R11 other write ignored");
    cfgRead(8'h06, d);
    check(d, 16'h0000, "R11 other read zero");
    cfgWrite(8'h04, 2'b11, 16'h0000);
  endtask

  task automatic t_traffic();
    cfgWrite(8'h04, 2'b11, 16'h0004);
    @(negedge clk); dnReq = 1; #1;
    check({dnFwd, dnAbort}, 2'b10, "R3 bus master forwards");
    dnReq = 0; #1;
    check({dnFwd, dnAbort}, 2'b00, "R3 idle");
    @(negedge clk); upMemReq = 1; upMemHit = 1; upIoReq = 1; upIoHit = 1; #1;
    check({upMemFwd, upMemAbort}, 2'b01, "R4 memory disabled aborts");
    check({upIoFwd, upIoAbort}, 2'b01, "R5 io disabled aborts");
    upMemReq = 0; upIoReq = 0;
    cfgWrite(8'h04, 2'b11, 16'h0003);
    @(negedge clk); upMemReq = 1; upIoReq = 1; #1;
    check({upMemFwd, upMemAbort}, 2'b10, "R4 memory enabled forwards");
    check({upIoFwd, upIoAbort}, 2'b10, "R5 io enabled forwards");
    upMemHit = 0; upIoHit = 0; #1;
    check({upMemFwd, upMemAbort, upIoFwd, upIoAbort}, 4'b0000, "R4 R5 miss no action");
    dnReq = 1; #1;
    check({dnFwd, dnAbort}, 2'b01, "R3 bus master off aborts");
    dnReq = 0; upMemReq = 0; upIoReq = 0;
    cfgWrite(8'h04, 2'b11, 16'h0000);
  endtask

  task automatic t_intx();
    @(negedge clk); portEvent = 1;
    @(negedge clk);
    check({intxOwn, intxAssertMsg, intxDeassertMsg}, 3'b110, "R6 assert");
    @(negedge clk);
    check({intxOwn, intxAssertMsg}, 2'b10, "R6 assert single pulse");
    portEvent = 0;
    @(negedge clk);
    check({intxOwn, intxAssertMsg, intxDeassertMsg}, 3'b001, "R6 deassert");
    portEvent = 1;
    @(negedge clk); @(negedge clk);
    cfgWrite(8'h04, 2'b10, 16'h0400);
    @(negedge clk);
    check({intxOwn, intxDeassertMsg}, 2'b01, "R7 disable while asserted");
    @(negedge clk);
    check({intxOwn, intxAssertMsg, intxDeassertMsg}, 3'b000, "R7 stays quiet");
    cfgWrite(8'h04, 2'b11, 16'h0000);
    @(negedge clk);
    check(intxOwn, 1'b1, "R6 reasserts after clear");
    msiEn = 1;
    @(negedge clk);
    check({intxOwn, intxDeassertMsg}, 2'b01, "R7 msi while asserted");
    @(negedge clk);
    check({intxOwn, intxAssertMsg}, 2'b00, "R7 msi blocks");
    portEvent = 0; msiEn = 0;
    @(negedge clk);
  endtask

  task automatic t_fwd_intx();
    cfgWrite(8'h04, 2'b10, 16'h0400);
    @(negedge clk); msiEn = 1; dnIntxAssert = 1; #1;
    check(fwdIntxAssert, 1'b1, "R8 assert passes");
    dnIntxAssert = 0; dnIntxDeassert = 1; #1;
    check({fwdIntxAssert, fwdIntxDeassert}, 2'b01, "R8 deassert passes");
    dnIntxDeassert = 0; msiEn = 0;
    cfgWrite(8'h04, 2'b11, 16'h0000);
  endtask

  task automatic t_serr();
    int pulses;
    @(negedge clk); sysErrStatus = 1;
    pulses = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (serrMsg) pulses++;
    end
    check(pulses[15:0], 16'd0, "R9 disabled no message");
    sysErrStatus = 0;
    cfgWrite(8'h04, 2'b10, 16'h0100);
    @(negedge clk); sysErrStatus = 1;
    @(negedge clk);
    check(serrMsg, 1'b1, "R9 pulse on rise");
    pulses = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (serrMsg) pulses++;
    end
    check(pulses[15:0], 16'd0, "R9 not repeated");
    sysErrStatus = 0;
    cfgWrite(8'h04, 2'b11, 16'h0000);
  endtask

  task automatic t_parity();
    cfgWrite(8'h04, 2'b01, 16'h0040);
    #1 check(parErrRespEn, 1'b1, "R10 parity enable set");
    cfgWrite(8'h04, 2'b01, 16'h0000);
    #1 check(parErrRespEn, 1'b0, "R10 parity enable clear");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_reserved();
    t_other_addr();
    t_traffic();
    t_intx();
    t_fwd_intx();
    t_serr();
    t_parity();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(CLK_P * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule